// File: doc/BRIEF.md
# Disk Transfer Address Generator

This block produces the memory address for a floppy disk data path. A processor sets the start address one byte at a time through two registers used together. It first writes a byte selector to an index register. It then writes the address byte to a data register. It does this once for the low byte and once for the high byte, and each byte has its own preset strobe.

A control register selects one of four drives, enables the disk interrupt, sets the transfer direction, and gates address incrementing through an active-low enable bit. While incrementing is enabled, every completed transfer strobe advances the address by one. The count wraps at the top of the address space.

Each register write takes effect at the clock edge on which it is presented. The outputs show the new value from that edge onward. A small status byte reports whether the driver loader is busy, using an active-low flag.

Top module: `dskdma_addr_top`

## Requirements
- R1: While reset is high, and after it is released, the address is 0x0000, the drive select is 0, and the interrupt enable and direction outputs are 0. The stored increment-disable bit is 1, so transfer strobes leave the address unchanged.
- R2: Register code 0 is the index register and register code 1 is the data register. A data write while the index holds 0 loads bits 7:0 of the address. A data write while the index holds 1 loads bits 15:8. The new byte appears after that edge and the other byte is unchanged.
- R3: A data write while the index holds any value other than 0 or 1 leaves the address unchanged. A write to the spare register code 3 changes nothing.
- R4: Register code 2 is the control register. Its bits 1:0 drive the two-bit drive select output.
- R5: Control bit 2 drives the interrupt enable output, with 1 meaning enabled.
- R6: Control bit 3 is an active-low increment enable. While it is 1, transfer strobes do not change the address.
- R7: Control bit 4 drives the direction output, with 1 meaning memory-to-disk.
- R8: While control bit 3 is 0, each cycle with the transfer strobe high adds one to the address. Carries run through the chain of 4-bit stages (for example, 0x0FFF becomes 0x1000).
- R9: Incrementing from 0xFFFF gives 0x0000.
- R10: When a valid data write and a transfer strobe fall in the same cycle, the write wins. The addressed byte takes the written value, the other byte keeps its value, and no increment happens.
- R11: The status output has bit 7 equal to the inverse of the loader-busy input, and bits 6:0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write enable |
| bus_reg | input | 2 | Register code: 0 index, 1 data, 2 control, 3 spare |
| bus_wdata | input | 8 | Write data |
| xfer_stb | input | 1 | One-cycle pulse per completed transfer |
| ldr_busy | input | 1 | Driver loader busy, active high |
| dma_addr | output | 16 | Current transfer address |
| drv_sel | output | 2 | Drive select |
| irq_en | output | 1 | Interrupt enable |
| xfer_dir | output | 1 | Direction, 1 means memory-to-disk |
| status_q | output | 8 | Status byte, bit 7 is the active-low busy flag |

## Verification
The bench builds the block with its default of four 4-bit stages, which gives a 16-bit address. At this width every carry boundary can be reached by presetting the two bytes directly, so the bench does not need long counting runs. This covers the nibble carry at 0x0FFF, the full wrap at 0xFFFF, and the byte-level overlap of a preset with a strobe. It also covers invalid index values and the spare register code.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        RS_INDEX = 2'd0,
        RS_DATA  = 2'd1,
        RS_CTRL  = 2'd2,
        RS_SPARE = 2'd3
    } reg_sel_e;

    // Control byte, bit 4 down to bit 0
    typedef struct packed {
        logic       to_disk;
        logic       inc_n;
        logic       irq_on;
        logic [1:0] drive;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{to_disk: 1'b0, inc_n: 1'b1, irq_on: 1'b0, drive: 2'd0};

    function automatic logic [NIB_W-1:0] nib_pick(input logic [BYTE_W-1:0] b, input int half);
        return (half == 0) ? b[NIB_W-1:0] : b[BYTE_W-1:NIB_W];
    endfunction

endpackage

// File: rtl/dskdma_regs.sv
module dskdma_regs
    import dskdma_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_reg,
    input  logic [BYTE_W-1:0] bus_wdata,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] idx_q,
    output logic [BYTES-1:0]  ld_byte
);

    logic data_wr;
    assign data_wr = bus_we && (bus_reg == RS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            ctrl_q <= CTRL_RESET;
        end else if (bus_we) begin
            if (bus_reg == RS_INDEX)
                idx_q <= bus_wdata;
            else if (bus_reg == RS_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[4:0]);
        end
    end

    // One preset strobe per address byte
    for (genvar b = 0; b < BYTES; b++) begin : g_strobe
        assign ld_byte[b] = data_wr && (idx_q == BYTE_W'(b));
    end

endmodule

// File: rtl/dskdma_nib.sv
module dskdma_nib
    import dskdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [NIB_W-1:0] ld_val,
    input  logic             cin,
    output logic [NIB_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else if (cin)
            q <= q + NIB_W'(1);
    end

endmodule

// File: rtl/dskdma_ctr.sv
module dskdma_ctr
    import dskdma_pkg::*;
#(
    parameter int NIB_CNT = 4,
    localparam int ADDR_W = NIB_CNT * NIB_W,
    localparam int BYTES  = NIB_CNT / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTES-1:0]  ld_byte,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              inc_go,
    output logic [ADDR_W-1:0] q
);

    logic [NIB_CNT-1:0] carry;

    for (genvar k = 0; k < NIB_CNT; k++) begin : g_stage
        // Carry into stage k: all lower stages are at their maximum value
        if (k == 0) begin : g_first
            assign carry[k] = inc_go;
        end else begin : g_upper
            assign carry[k] = inc_go && (&q[k*NIB_W-1:0]);
        end

        dskdma_nib u_nib (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld_byte[k/2]),
            .ld_val (nib_pick(ld_data, k % 2)),
            .cin    (carry[k]),
            .q      (q[k*NIB_W +: NIB_W])
        );
    end

endmodule

// File: rtl/dskdma_addr_top.sv
module dskdma_addr_top
    import dskdma_pkg::*;
#(
    parameter int NIB_CNT = 4,
    localparam int ADDR_W = NIB_CNT * NIB_W,
    localparam int BYTES  = NIB_CNT / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_reg,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              xfer_stb,
    input  logic              ldr_busy,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [1:0]        drv_sel,
    output logic              irq_en,
    output logic              xfer_dir,
    output logic [BYTE_W-1:0] status_q
);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] idx_q;
    logic [BYTES-1:0]  ld_byte;
    logic              inc_off;
    logic              inc_go;

    dskdma_regs #(.BYTES(BYTES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .idx_q     (idx_q),
        .ld_byte   (ld_byte)
    );

    assign inc_off = ctrl_q.inc_n;
    // A preset in the same cycle wins over the strobe
    assign inc_go  = xfer_stb && !inc_off && !(|ld_byte);

    dskdma_ctr #(.NIB_CNT(NIB_CNT)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .ld_byte (ld_byte),
        .ld_data (bus_wdata),
        .inc_go  (inc_go),
        .q       (dma_addr)
    );

    assign drv_sel  = ctrl_q.drive;
    assign irq_en   = ctrl_q.irq_on;
    assign xfer_dir = ctrl_q.to_disk;
    assign status_q = {~ldr_busy, {(BYTE_W-1){1'b0}}};

endmodule

// File: rtl/dskdma_chk.sv
module dskdma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [1:0]        bus_reg,
    input logic [7:0]        bus_wdata,
    input logic              xfer_stb,
    input logic [7:0]        idx_q,
    input logic              inc_off,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [1:0]        drv_sel,
    input logic              irq_en,
    input logic              xfer_dir
);

    logic ld_any;
    assign ld_any = bus_we && (bus_reg == 2'd1) && (idx_q < 8'd2);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (dma_addr == '0) && (drv_sel == 2'd0) && !irq_en && !xfer_dir && inc_off);

    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && !inc_off && !ld_any) |=> dma_addr == $past(dma_addr) + ADDR_W'(1));

    // R6
    inc_block_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_off && !ld_any) |=> $stable(dma_addr));

    // R10
    lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_reg == 2'd1 && idx_q == 8'd0) |=>
            (dma_addr[7:0] == $past(bus_wdata)) && (dma_addr[ADDR_W-1:8] == $past(dma_addr[ADDR_W-1:8])));

    // R2
    hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_reg == 2'd1 && idx_q == 8'd1) |=>
            (dma_addr[ADDR_W-1:8] == $past(bus_wdata)) && (dma_addr[7:0] == $past(dma_addr[7:0])));

    // R4
    ctrl_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_reg == 2'd2) |=>
            (drv_sel == $past(bus_wdata[1:0])) && (irq_en == $past(bus_wdata[2])) && (xfer_dir == $past(bus_wdata[4])));

endmodule

bind dskdma_addr_top dskdma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_reg   (bus_reg),
    .bus_wdata (bus_wdata),
    .xfer_stb  (xfer_stb),
    .idx_q     (idx_q),
    .inc_off   (inc_off),
    .dma_addr  (dma_addr),
    .drv_sel   (drv_sel),
    .irq_en    (irq_en),
    .xfer_dir  (xfer_dir)
);

// File: tb/sim_dskdma_addr_top.sv
module sim_dskdma_addr_top;

    typedef struct {
        logic [15:0] addr;
        logic [1:0]  drv;
        logic        irq;
        logic        dir;
        logic [7:0]  stat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_reg = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic        xfer_stb = 1'b0;
    logic        ldr_busy = 1'b0;
    logic [15:0] dma_addr;
    logic [1:0]  drv_sel;
    logic        irq_en;
    logic        xfer_dir;
    logic [7:0]  status_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t sb[$];

    logic [15:0] m_addr = 16'd0;
    logic [7:0]  m_idx  = 8'd0;
    logic [4:0]  m_ctrl = 5'b01000;

    always #10 clk = ~clk;

    dskdma_addr_top u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .xfer_stb(xfer_stb), .ldr_busy(ldr_busy), .dma_addr(dma_addr), .drv_sel(drv_sel),
        .irq_en(irq_en), .xfer_dir(xfer_dir), .status_q(status_q)
    );

    // Driver: one bus cycle per call, expected result pushed to the scoreboard
    task automatic op(input logic we, input logic [1:0] rg, input logic [7:0] d,
                      input logic stb, input logic busy, input string tag);
        exp_t e;
        logic loaded;
        logic [4:0] old_ctrl;
        @(negedge clk);
        bus_we = we; bus_reg = rg; bus_wdata = d; xfer_stb = stb; ldr_busy = busy;
        loaded = 1'b0;
        old_ctrl = m_ctrl;
        if (we) begin
            case (rg)
                2'd0: m_idx = d;
                2'd1: begin
                    if (m_idx == 8'd0) begin m_addr[7:0] = d; loaded = 1'b1; end
                    else if (m_idx == 8'd1) begin m_addr[15:8] = d; loaded = 1'b1; end
                end
                2'd2: m_ctrl = d[4:0];
                default: ;
            endcase
        end
        if (stb && !old_ctrl[3] && !loaded) m_addr = m_addr + 16'd1;
        e.addr = m_addr; e.drv = m_ctrl[1:0]; e.irq = m_ctrl[2]; e.dir = m_ctrl[4];
        e.stat = {~busy, 7'd0}; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic preset(input logic [15:0] a, input string tag);
        op(1'b1, 2'd0, 8'd0, 1'b0, 1'b0, tag);
        op(1'b1, 2'd1, a[7:0], 1'b0, 1'b0, tag);
        op(1'b1, 2'd0, 8'd1, 1'b0, 1'b0, tag);
        op(1'b1, 2'd1, a[15:8], 1'b0, 1'b0, tag);
    endtask

    // Monitor: samples 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dma_addr !== e.addr || drv_sel !== e.drv || irq_en !== e.irq ||
                    xfer_dir !== e.dir || status_q !== e.stat) begin
                    errors++;
                    $display("FAIL %s: got addr=%h drv=%0d irq=%b dir=%b stat=%h, expected addr=%h drv=%0d irq=%b dir=%b stat=%h",
                             e.tag, dma_addr, drv_sel, irq_en, xfer_dir, status_q,
                             e.addr, e.drv, e.irq, e.dir, e.stat);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then a strobe is ignored while increment is disabled
        op(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R1 reset state");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R1 strobe after reset");
        // R2: byte presets through index and data
        op(1'b1, 2'd0, 8'd0, 1'b0, 1'b0, "R2 index low");
        op(1'b1, 2'd1, 8'h34, 1'b0, 1'b0, "R2 low byte");
        op(1'b1, 2'd0, 8'd1, 1'b0, 1'b0, "R2 index high");
        op(1'b1, 2'd1, 8'h12, 1'b0, 1'b0, "R2 high byte");
        // R6: disabled increment
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R6 strobe blocked");
        // R8: enable and count
        op(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, "R6 enable increment");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R8 single step");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R8 second step");
        // R4 R5 R7: control fields
        op(1'b1, 2'd2, 8'h17, 1'b0, 1'b0, "R4 R5 R7 drive3 irq dir");
        op(1'b1, 2'd2, 8'h02, 1'b0, 1'b0, "R4 drive2 irq off dir off");
        op(1'b1, 2'd2, 8'h11, 1'b0, 1'b0, "R7 drive1 dir on");
        // R8: carry across stages
        preset(16'h0FFF, "R8 preset 0FFF");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R8 carry 0FFF to 1000");
        preset(16'h00FF, "R8 preset 00FF");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R8 carry 00FF to 0100");
        // R9: wrap
        preset(16'hFFFF, "R9 preset FFFF");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R9 wrap to 0000");
        // R10: preset collides with strobe
        preset(16'hA0FF, "R10 preset A0FF");
        op(1'b1, 2'd0, 8'd0, 1'b0, 1'b0, "R10 index low");
        op(1'b1, 2'd1, 8'h55, 1'b1, 1'b0, "R10 low load beats strobe");
        op(1'b1, 2'd0, 8'd1, 1'b0, 1'b0, "R10 index high");
        op(1'b1, 2'd1, 8'h3C, 1'b1, 1'b0, "R10 high load beats strobe");
        // R3: ignored writes
        op(1'b1, 2'd0, 8'd5, 1'b0, 1'b0, "R3 invalid index");
        op(1'b1, 2'd1, 8'hAA, 1'b0, 1'b0, "R3 data write ignored");
        op(1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, "R3 spare code ignored");
        op(1'b1, 2'd1, 8'h77, 1'b1, 1'b0, "R3 ignored write does not block step");
        // R11: status flag
        op(1'b0, 2'd0, 8'd0, 1'b0, 1'b1, "R11 loader busy");
        op(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R11 loader idle");
        // R6: disable again
        op(1'b1, 2'd2, 8'h08, 1'b0, 1'b0, "R6 disable increment");
        op(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, "R6 strobe blocked again");
        op(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R6 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule